// File: doc/BRIEF.md
# Three-Digit Sequential Code Lock

This block is the controller of an electronic door lock. A keypad front end hands it one digit per cycle together with a one-cycle strobe. The lock compares each strobed digit against a stored secret, one stage at a time. It raises its unlock output only when three strobed digits have matched the three secret digits in the stored order. Any wrong digit sends the lock into a fault state. The lock then ignores all further digits until it is reset. Once unlocked, the lock also ignores further digits and stays unlocked until reset.

Internally the block is split into a datapath and a controller. The datapath holds the three secret digits in registers, which are loaded from parameters on reset. A one-hot selector picks the secret digit for the current stage, and an equality comparator checks it against the entered digit. The controller is a four-bit state register. Its encoding is chosen so that its low three bits are the selector's one-hot select and its top bit is the unlock output, so neither needs any decoding. Two selector implementations, an AND-OR tree or a priority chain, can be chosen by parameter.

Top module: `seq_code_lock`

## Requirements
- R1: A synchronous active-high reset returns the lock to its first stage from any state, and unlock_o reads 0 in the cycle after reset.
- R2: Strobing the three secret digits in order (defaults 3, then 4, then 2) drives unlock_o to 1 in the cycle after the third strobe's clock edge, and unlock_o stays 0 after the first and second strobes.
- R3: A cycle with strobe_i low changes nothing: idle cycles between correct digits neither unlock nor spoil the sequence.
- R4: A strobed digit that differs from the selected secret digit in any bit, at any of the three stages, sends the lock to the fault state, and unlock_o stays 0.
- R5: The fault state holds until reset: a later complete correct sequence does not unlock.
- R6: The unlocked state holds until reset: further strobes with any digit leave unlock_o at 1.
- R7: When reset and strobe_i are high in the same cycle, the reset wins and the strobed digit is not consumed as a first-stage entry.
- R8: Order matters: the correct digits entered in another order (for example 4, 3, 2), or with a digit repeated, do not unlock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset, priority over strobe_i |
| strobe_i | input | 1 | One-cycle pulse: digit_i holds a new entry this cycle |
| digit_i | input | DIGIT_W | Entered digit, sampled when strobe_i is high |
| unlock_o | output | 1 | 1 while the lock is open, 0 otherwise |

## Verification
The correct sequence is entered both back-to-back and with idle gaps. This shows that only strobed cycles advance the lock. Wrong digits are placed at the first, second and third stage, including one that differs from the secret only in its top bit. Each of these must leave the lock shut even when a correct sequence follows, which shows that the fault state is sticky. Permuted and repeated digits separate a lock that checks order from one that only checks membership. A reset asserted together with a strobe carrying the first secret digit shows whether that digit was wrongly counted.

// File: rtl/seq_code_lock_pkg.sv
package seq_code_lock_pkg;

   // Number of digits in a secret; the state encoding below is built for three.
   localparam int unsigned STAGES = 3;
   localparam int unsigned STATE_W = STAGES + 1;

   // Low STAGES bits: one-hot stage select. Top bit: unlocked.
   // All zero: fault. Advancing a stage is a left shift by one.
   typedef enum logic [STATE_W-1:0] {
      ST_FAULT    = 4'b0000,
      ST_WAIT1    = 4'b0001,
      ST_WAIT2    = 4'b0010,
      ST_WAIT3    = 4'b0100,
      ST_UNLOCKED = 4'b1000
   } lock_state_e;

   // Selector implementation variants.
   localparam int unsigned MUX_ANDOR    = 0;
   localparam int unsigned MUX_PRIORITY = 1;

endpackage

// File: rtl/lock_code_path.sv
module lock_code_path
   import seq_code_lock_pkg::*;
#(
   parameter int unsigned DIGIT_W   = 4,
   parameter int unsigned SECRET_A  = 3,
   parameter int unsigned SECRET_B  = 4,
   parameter int unsigned SECRET_C  = 2,
   parameter int unsigned MUX_STYLE = MUX_ANDOR
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic [STAGES-1:0]  sel_i,
   input  logic [DIGIT_W-1:0] digit_i,
   output logic               match_o
);

   localparam logic [DIGIT_W-1:0] SECRET_TABLE [STAGES] = '{
      DIGIT_W'(SECRET_A), DIGIT_W'(SECRET_B), DIGIT_W'(SECRET_C)
   };

   // Elaboration-time parameter checks.
   generate
      if (DIGIT_W < 1 || DIGIT_W > 16) begin : g_bad_width
         $error("lock_code_path: DIGIT_W out of range");
      end
      if (SECRET_A >= (1 << DIGIT_W) || SECRET_B >= (1 << DIGIT_W) ||
          SECRET_C >= (1 << DIGIT_W)) begin : g_bad_secret
         $error("lock_code_path: secret digit does not fit DIGIT_W");
      end
      if (MUX_STYLE != MUX_ANDOR && MUX_STYLE != MUX_PRIORITY) begin : g_bad_mux
         $error("lock_code_path: unknown MUX_STYLE");
      end
   endgenerate

   // Secret digit registers, loaded on reset.
   logic [DIGIT_W-1:0] secret_q [STAGES];

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_secret
         always_ff @(posedge clk_i) begin
            if (rst_i) begin
               secret_q[g] <= SECRET_TABLE[g];
            end
         end
      end
   endgenerate

   // One-hot selector, two variants.
   logic [DIGIT_W-1:0] picked;

   generate
      if (MUX_STYLE == MUX_ANDOR) begin : g_mux_andor
         always_comb begin
            picked = '0;
            for (int k = 0; k < STAGES; k++) begin
               picked = picked | (secret_q[k] & {DIGIT_W{sel_i[k]}});
            end
         end
      end else begin : g_mux_prio
         always_comb begin
            picked = '0;
            for (int k = STAGES - 1; k >= 0; k--) begin
               if (sel_i[k]) begin
                  picked = secret_q[k];
               end
            end
         end
      end
   endgenerate

   // Equality comparator; meaningless when no stage is selected.
   assign match_o = (|sel_i) && (picked == digit_i);

   // The selector must never see more than one stage at once (R2).
   p_sel_onehot_r2 : assert property (@(posedge clk_i) disable iff (rst_i)
      $onehot0(sel_i));

   // With no stage selected the comparator reports no match (R5, R6).
   p_idle_nomatch_r5 : assert property (@(posedge clk_i) disable iff (rst_i)
      (sel_i == '0) |-> !match_o);

endmodule

// File: rtl/lock_seq_ctrl.sv
module lock_seq_ctrl
   import seq_code_lock_pkg::*;
(
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               strobe_i,
   input  logic               match_i,
   output logic [STAGES-1:0]  sel_o,
   output logic               unlock_o
);

   generate
      if (STAGES != 3 || STATE_W != 4) begin : g_bad_enc
         $error("lock_seq_ctrl: encoding assumes three stages");
      end
   endgenerate

   lock_state_e state_q;
   lock_state_e state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_WAIT1, ST_WAIT2, ST_WAIT3: begin
            if (strobe_i) begin
               state_d = match_i ? lock_state_e'(state_q << 1) : ST_FAULT;
            end
         end
         ST_UNLOCKED: state_d = ST_UNLOCKED;
         ST_FAULT:    state_d = ST_FAULT;
         default:     state_d = ST_FAULT;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q <= ST_WAIT1;
      end else begin
         state_q <= state_d;
      end
   end

   // Outputs are state bits, no decode.
   assign sel_o    = state_q[STAGES-1:0];
   assign unlock_o = state_q[STATE_W-1];

   // Reset (with or without strobe) lands in the first stage (R1, R7).
   p_reset_first_r1 : assert property (@(posedge clk_i)
      rst_i |=> (state_q == ST_WAIT1));

   // No strobe, no change (R3).
   p_hold_idle_r3 : assert property (@(posedge clk_i) disable iff (rst_i)
      !strobe_i |=> $stable(state_q));

   // A mismatch while a stage is active ends in fault (R4).
   p_miss_faults_r4 : assert property (@(posedge clk_i) disable iff (rst_i)
      (strobe_i && (sel_o != '0) && !match_i) |=> (state_q == ST_FAULT));

   // Fault is sticky (R5).
   p_fault_sticky_r5 : assert property (@(posedge clk_i) disable iff (rst_i)
      (state_q == ST_FAULT) |=> (state_q == ST_FAULT));

   // Unlocked is sticky (R6).
   p_open_sticky_r6 : assert property (@(posedge clk_i) disable iff (rst_i)
      unlock_o |=> unlock_o);

   // Unlock only follows a matching strobe from the last stage (R2).
   p_open_entry_r2 : assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(unlock_o) |-> $past(sel_o[STAGES-1] && strobe_i && match_i));

endmodule

// File: rtl/seq_code_lock.sv
module seq_code_lock
   import seq_code_lock_pkg::*;
#(
   parameter int unsigned DIGIT_W   = 4,
   parameter int unsigned SECRET_A  = 3,
   parameter int unsigned SECRET_B  = 4,
   parameter int unsigned SECRET_C  = 2,
   parameter int unsigned MUX_STYLE = MUX_ANDOR
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               strobe_i,
   input  logic [DIGIT_W-1:0] digit_i,
   output logic               unlock_o
);

   logic [STAGES-1:0] stage_sel;
   logic              digit_match;

   lock_code_path #(
      .DIGIT_W   (DIGIT_W),
      .SECRET_A  (SECRET_A),
      .SECRET_B  (SECRET_B),
      .SECRET_C  (SECRET_C),
      .MUX_STYLE (MUX_STYLE)
   ) path_i (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .sel_i   (stage_sel),
      .digit_i (digit_i),
      .match_o (digit_match)
   );

   lock_seq_ctrl ctrl_i (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .strobe_i (strobe_i),
      .match_i  (digit_match),
      .sel_o    (stage_sel),
      .unlock_o (unlock_o)
   );

   // While unlocked no stage is selected (R6).
   p_open_nosel_r6 : assert property (@(posedge clk_i) disable iff (rst_i)
      unlock_o |-> (stage_sel == '0));

endmodule

// File: tb/seq_code_lock_tb_top.sv
module seq_code_lock_tb_top;

   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst;
   logic         strobe;
   logic [W-1:0] digit;
   logic         unlock;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;  // 125 MHz

   seq_code_lock dut_i (
      .clk_i    (clk),
      .rst_i    (rst),
      .strobe_i (strobe),
      .digit_i  (digit),
      .unlock_o (unlock)
   );

   task automatic check(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s unlock actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; strobe = 1'b0; digit = '0;
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic enter(input logic [W-1:0] v);
      @(negedge clk);
      strobe = 1'b1; digit = v;
      @(negedge clk);
      strobe = 1'b0; digit = '0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset();
      do_reset();
      check(unlock, 1'b0, "R1 after reset");
   endtask

   task automatic t_good();
      do_reset();
      enter(4'd3); check(unlock, 1'b0, "R2 after first");
      enter(4'd4); check(unlock, 1'b0, "R2 after second");
      enter(4'd2); check(unlock, 1'b1, "R2 after third");
   endtask

   task automatic t_gaps();
      do_reset();
      enter(4'd3); idle(5); check(unlock, 1'b0, "R3 idle after first");
      enter(4'd4); idle(3); check(unlock, 1'b0, "R3 idle after second");
      enter(4'd2); check(unlock, 1'b1, "R3 gapped sequence");
   endtask

   task automatic t_miss();
      do_reset();
      enter(4'd5); enter(4'd3); enter(4'd4); enter(4'd2);
      check(unlock, 1'b0, "R4 wrong first digit");
      do_reset();
      enter(4'd3); enter(4'd7); enter(4'd4); enter(4'd2);
      check(unlock, 1'b0, "R4 wrong second digit");
      do_reset();
      enter(4'd3); enter(4'd4); enter(4'd10);
      check(unlock, 1'b0, "R4 third digit top bit wrong");
   endtask

   task automatic t_fault_sticky();
      do_reset();
      enter(4'd1); idle(2);
      enter(4'd3); enter(4'd4); enter(4'd2);
      check(unlock, 1'b0, "R5 fault then full sequence");
      enter(4'd3); enter(4'd4); enter(4'd2);
      check(unlock, 1'b0, "R5 fault then second sequence");
      do_reset();
      check(unlock, 1'b0, "R1 reset out of fault");
      enter(4'd3); enter(4'd4); enter(4'd2);
      check(unlock, 1'b1, "R5 reset clears fault");
   endtask

   task automatic t_open_sticky();
      do_reset();
      enter(4'd3); enter(4'd4); enter(4'd2);
      enter(4'd0); check(unlock, 1'b1, "R6 strobe 0 while open");
      enter(4'd9); enter(4'd3); check(unlock, 1'b1, "R6 more strobes while open");
      idle(4); check(unlock, 1'b1, "R6 idle while open");
   endtask

   task automatic t_reset_prio();
      do_reset();
      enter(4'd3); enter(4'd4); enter(4'd2);
      @(negedge clk);
      rst = 1'b1; strobe = 1'b1; digit = 4'd3;
      @(negedge clk);
      rst = 1'b0; strobe = 1'b0; digit = '0;
      check(unlock, 1'b0, "R7 reset with strobe closes");
      enter(4'd4); enter(4'd2);
      check(unlock, 1'b0, "R7 strobed digit not consumed");
      do_reset();
      enter(4'd3); enter(4'd4); enter(4'd2);
      check(unlock, 1'b1, "R7 normal sequence after");
   endtask

   task automatic t_order();
      do_reset();
      enter(4'd4); enter(4'd3); enter(4'd2);
      check(unlock, 1'b0, "R8 permuted order");
      do_reset();
      enter(4'd3); enter(4'd3); enter(4'd4); enter(4'd2);
      check(unlock, 1'b0, "R8 repeated first digit");
   endtask

   initial begin
      rst = 1'b1; strobe = 1'b0; digit = '0;
      t_reset();
      t_good();
      t_gaps();
      t_miss();
      t_fault_sticky();
      t_open_sticky();
      t_reset_prio();
      t_order();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule